// File: doc/BRIEF.md
# Bayer White-Balance Gain and Offset Stage

This block sits in a raw-sensor capture path and scales each incoming Bayer pixel by a per-color white-balance gain, then adds one offset shared by every color. It works out each pixel's color from its position alone. Two parity bits track the position: whether the pixel is on an odd or even line, and whether it is an odd or even pixel within that line. A field flag latched at frame start selects which of two pattern tables applies. Together these pick a 2-bit color code from a programmable pattern word, and the code selects one of four fixed-point gains.

The block has three registered output paths: one toward memory, one toward the processing pipeline and one toward the statistics engine. Each path has its own gain enable and offset enable. From the same input pixel, a path can therefore produce the gained-and-offset value, the gained value, the offset value, or the untouched pixel. All configuration inputs are static register values. Software changes them only while no pixels are in flight.

Top module: `bayer_wb_gain`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `out_valid` is 0 and all three path outputs are 0.
- R2: A pixel presented with `pix_valid` high before clock edge k gives `out_valid` high, and its results on all three paths, after edge k+1. This is a latency of two registers.
- R3: With a path's gain enable set, the gained value is the pixel times the 12-bit gain (3 integer bits above 9 fraction bits), divided by 512 and rounded to nearest, with halves rounding up. A gain of 0x200 is unity.
- R4: With a path's offset enable set, `cfg_offset` is added after the gain stage. Any result above 4095 is clamped to 4095.
- R5: The enables for each path are independent. Bit 0 of `cfg_gain_en`/`cfg_ofs_en` is the memory path, bit 1 the pipeline path and bit 2 the statistics path. A path with both enables clear outputs the input pixel unchanged, with the same latency.
- R6: The color code is `cfg_color_pat[2*s+1:2*s]`, with s = 4*field + 2*line_even + pix_even. For field 0 this gives bits [1:0] for odd line/odd pixel, [3:2] for odd line/even pixel, [5:4] for even line/odd pixel and [7:6] for even line/even pixel. Bits [15:8] hold the same layout for field 1.
- R7: Code 0 selects `cfg_gain_r`, code 1 `cfg_gain_gr`, code 2 `cfg_gain_gb` and code 3 `cfg_gain_b`.
- R8: `frame_start` makes the current line odd. A `line_start` without `frame_start` toggles line parity. Either strobe applies to a pixel presented in the same cycle. After reset the line is odd.
- R9: Each pixel with `pix_valid` high is followed by a toggle of pixel parity. `line_start` or `frame_start` makes the pixel in that cycle odd. Cycles with `pix_valid` low do not advance parity.
- R10: `field_id` is sampled only in a `frame_start` cycle and holds for the rest of the frame. Changes at other times have no effect. The field after reset is 0.
- R11: When no pixel is delivered (`out_valid` low), all three path outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Input pixel qualifier |
| line_start | input | 1 | Strobe marking the start of a line |
| frame_start | input | 1 | Strobe marking the start of a frame, also a line start |
| field_id | input | 1 | Field of the frame, sampled with `frame_start` |
| pix_in | input | 12 | Raw pixel value |
| cfg_gain_r | input | 12 | Gain for color code 0 (R/Ye), 3.9 fixed point |
| cfg_gain_gr | input | 12 | Gain for color code 1 (Gr/Cy) |
| cfg_gain_gb | input | 12 | Gain for color code 2 (Gb/G) |
| cfg_gain_b | input | 12 | Gain for color code 3 (B/Mg) |
| cfg_color_pat | input | 16 | Eight 2-bit color codes, indexed by field and parity |
| cfg_offset | input | 12 | Offset shared by all colors |
| cfg_gain_en | input | 3 | Gain enable per path (bit 0 memory, 1 pipeline, 2 statistics) |
| cfg_ofs_en | input | 3 | Offset enable per path, same bit order |
| out_valid | output | 1 | Output qualifier shared by all paths |
| out_mem | output | 12 | Memory path result |
| out_pipe | output | 12 | Pipeline path result |
| out_stat | output | 12 | Statistics path result |

## Verification
The bench focuses on parity edges: line strobes on idle cycles, pixel gaps inside lines, and strobes that fall in the same cycle as a pixel. A tracker that advanced pixel parity on idle cycles, or that let the strobe act one cycle late, would apply the neighbouring color's gain to whole runs of pixels. Frames are driven in both fields, and `field_id` changes in the middle of each frame; a design that sampled the field every cycle would jump between the two pattern halves. Gains of exactly one half with odd pixels expose truncation in place of rounding. Maximum gains and offsets expose wrap-around where the output should clamp at 4095. Enable combinations that differ from path to path catch paths that share an enable or add the offset before the gain.

// File: rtl/bwg_pkg.sv
`timescale 1ns/1ps
package bwg_pkg;

    localparam int unsigned CODE_W          = 2;
    localparam int unsigned SLOTS_PER_FIELD = 4;
    localparam int unsigned NUM_FIELDS      = 2;
    localparam int unsigned NUM_COLORS      = 4;
    localparam int unsigned NUM_PATHS       = 3;
    localparam int unsigned PAT_W           = CODE_W * SLOTS_PER_FIELD * NUM_FIELDS;

    typedef enum logic [CODE_W-1:0] {
        CC_R_YE  = 2'd0,
        CC_GR_CY = 2'd1,
        CC_GB_G  = 2'd2,
        CC_B_MG  = 2'd3
    } color_code_e;

    typedef enum int unsigned {
        PATH_MEM  = 0,
        PATH_PIPE = 1,
        PATH_STAT = 2
    } path_e;

    typedef struct packed {
        logic field;
        logic line_even;
        logic pix_even;
    } slot_pos_t;

    // Bit position of the 2-bit code for one position inside the pattern word.
    function automatic int unsigned slot_lsb(slot_pos_t p);
        int unsigned lsb;
        lsb = 0;
        if (p.field)     lsb = lsb + CODE_W * SLOTS_PER_FIELD;
        if (p.line_even) lsb = lsb + CODE_W * 2;
        if (p.pix_even)  lsb = lsb + CODE_W;
        return lsb;
    endfunction

endpackage

// File: rtl/bwg_pos_track.sv
`timescale 1ns/1ps
module bwg_pos_track
    import bwg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pix_valid,
    input  logic      line_start,
    input  logic      frame_start,
    input  logic      field_id,
    output slot_pos_t pos
);

    logic line_odd_q, pix_odd_q, field_q;
    logic line_odd_d, pix_odd_d, field_d;

    // Strobes act on the pixel of the same cycle.
    always_comb begin
        field_d = frame_start ? field_id : field_q;
        if (frame_start)
            line_odd_d = 1'b1;
        else if (line_start)
            line_odd_d = ~line_odd_q;
        else
            line_odd_d = line_odd_q;
        pix_odd_d = (frame_start || line_start) ? 1'b1 : pix_odd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_odd_q <= 1'b1;
            pix_odd_q  <= 1'b1;
            field_q    <= 1'b0;
        end else begin
            line_odd_q <= line_odd_d;
            pix_odd_q  <= pix_valid ? ~pix_odd_d : pix_odd_d;
            field_q    <= field_d;
        end
    end

    always_comb begin
        pos.field     = field_d;
        pos.line_even = ~line_odd_d;
        pos.pix_even  = ~pix_odd_d;
    end

endmodule

// File: rtl/bwg_gain_pick.sv
`timescale 1ns/1ps
module bwg_gain_pick
    import bwg_pkg::*;
#(
    parameter int GAIN_W = 12
) (
    input  logic [PAT_W-1:0]             pattern,
    input  slot_pos_t                    pos,
    input  logic [NUM_COLORS*GAIN_W-1:0] gains,
    output logic [GAIN_W-1:0]            gain
);

    color_code_e code;

    always_comb begin
        code = color_code_e'(pattern[slot_lsb(pos) +: CODE_W]);
        gain = gains[int'(code) * GAIN_W +: GAIN_W];
    end

endmodule

// File: rtl/bwg_scale.sv
`timescale 1ns/1ps
module bwg_scale #(
    parameter int PIX_W    = 12,
    parameter int GAIN_W   = 12,
    parameter int FRAC_W   = 9,
    parameter int SCALED_W = PIX_W + GAIN_W + 1 - FRAC_W
) (
    input  logic [PIX_W-1:0]    pix,
    input  logic [GAIN_W-1:0]   gain,
    output logic [SCALED_W-1:0] scaled
);

    localparam int PROD_W = PIX_W + GAIN_W + 1;
    localparam logic [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (FRAC_W - 1);

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod   = PROD_W'(pix) * PROD_W'(gain) + HALF_LSB;
        scaled = SCALED_W'(prod >> FRAC_W);
    end

endmodule

// File: rtl/bwg_lane.sv
`timescale 1ns/1ps
module bwg_lane #(
    parameter int PIX_W    = 12,
    parameter int OFS_W    = 12,
    parameter int SCALED_W = 16
) (
    input  logic [PIX_W-1:0]    pix,
    input  logic [SCALED_W-1:0] scaled,
    input  logic [OFS_W-1:0]    ofs,
    input  logic                gain_en,
    input  logic                ofs_en,
    output logic [PIX_W-1:0]    res
);

    localparam int WIDEST = (SCALED_W > OFS_W) ? ((SCALED_W > PIX_W) ? SCALED_W : PIX_W)
                                               : ((OFS_W > PIX_W) ? OFS_W : PIX_W);
    localparam int SUM_W  = WIDEST + 1;
    localparam logic [PIX_W-1:0] PIX_MAX = '1;

    logic [SUM_W-1:0] base, sum;

    always_comb begin
        base = gain_en ? SUM_W'(scaled) : SUM_W'(pix);
        sum  = base + (ofs_en ? SUM_W'(ofs) : SUM_W'(0));
        res  = (sum > SUM_W'(PIX_MAX)) ? PIX_MAX : sum[PIX_W-1:0];
    end

endmodule

// File: rtl/bayer_wb_gain.sv
`timescale 1ns/1ps
module bayer_wb_gain
    import bwg_pkg::*;
#(
    parameter int PIX_W       = 12,
    parameter int GAIN_INT_W  = 3,
    parameter int GAIN_FRAC_W = 9,
    parameter int OFS_W       = 12
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            pix_valid,
    input  logic                            line_start,
    input  logic                            frame_start,
    input  logic                            field_id,
    input  logic [PIX_W-1:0]                pix_in,
    input  logic [GAIN_INT_W+GAIN_FRAC_W-1:0] cfg_gain_r,
    input  logic [GAIN_INT_W+GAIN_FRAC_W-1:0] cfg_gain_gr,
    input  logic [GAIN_INT_W+GAIN_FRAC_W-1:0] cfg_gain_gb,
    input  logic [GAIN_INT_W+GAIN_FRAC_W-1:0] cfg_gain_b,
    input  logic [PAT_W-1:0]                cfg_color_pat,
    input  logic [OFS_W-1:0]                cfg_offset,
    input  logic [NUM_PATHS-1:0]            cfg_gain_en,
    input  logic [NUM_PATHS-1:0]            cfg_ofs_en,
    output logic                            out_valid,
    output logic [PIX_W-1:0]                out_mem,
    output logic [PIX_W-1:0]                out_pipe,
    output logic [PIX_W-1:0]                out_stat
);

    localparam int GAIN_W   = GAIN_INT_W + GAIN_FRAC_W;
    localparam int SCALED_W = PIX_W + GAIN_W + 1 - GAIN_FRAC_W;

    // Stage 0: position and gain selection
    slot_pos_t                     pos;
    logic [NUM_COLORS*GAIN_W-1:0]  gain_vec;
    logic [GAIN_W-1:0]             gain_sel;

    assign gain_vec = {cfg_gain_b, cfg_gain_gb, cfg_gain_gr, cfg_gain_r};

    bwg_pos_track i_pos (
        .clk        (clk),
        .rst        (rst),
        .pix_valid  (pix_valid),
        .line_start (line_start),
        .frame_start(frame_start),
        .field_id   (field_id),
        .pos        (pos)
    );

    bwg_gain_pick #(.GAIN_W(GAIN_W)) i_pick (
        .pattern(cfg_color_pat),
        .pos    (pos),
        .gains  (gain_vec),
        .gain   (gain_sel)
    );

    // Stage 1 registers
    logic              s1_valid;
    logic [PIX_W-1:0]  s1_pix;
    logic [GAIN_W-1:0] s1_gain;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_pix   <= '0;
            s1_gain  <= '0;
        end else begin
            s1_valid <= pix_valid;
            if (pix_valid) begin
                s1_pix  <= pix_in;
                s1_gain <= gain_sel;
            end
        end
    end

    // Stage 2: one shared multiplier, per-path enable lanes
    logic [SCALED_W-1:0] scaled;
    logic [PIX_W-1:0]    lane_res [NUM_PATHS];
    logic [PIX_W-1:0]    out_q    [NUM_PATHS];

    bwg_scale #(
        .PIX_W   (PIX_W),
        .GAIN_W  (GAIN_W),
        .FRAC_W  (GAIN_FRAC_W),
        .SCALED_W(SCALED_W)
    ) i_scale (
        .pix   (s1_pix),
        .gain  (s1_gain),
        .scaled(scaled)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        bwg_lane #(
            .PIX_W   (PIX_W),
            .OFS_W   (OFS_W),
            .SCALED_W(SCALED_W)
        ) i_lane (
            .pix    (s1_pix),
            .scaled (scaled),
            .ofs    (cfg_offset),
            .gain_en(cfg_gain_en[p]),
            .ofs_en (cfg_ofs_en[p]),
            .res    (lane_res[p])
        );

        always_ff @(posedge clk) begin
            if (rst)
                out_q[p] <= '0;
            else if (s1_valid)
                out_q[p] <= lane_res[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= s1_valid;
    end

    assign out_mem  = out_q[PATH_MEM];
    assign out_pipe = out_q[PATH_PIPE];
    assign out_stat = out_q[PATH_STAT];

endmodule

// File: rtl/bwg_checker.sv
`timescale 1ns/1ps
module bwg_checker #(
    parameter int PIX_W = 12,
    parameter int NUM_P = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             pix_valid,
    input logic [PIX_W-1:0] pix_in,
    input logic [NUM_P-1:0] cfg_gain_en,
    input logic [NUM_P-1:0] cfg_ofs_en,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_mem,
    input logic [PIX_W-1:0] out_pipe,
    input logic [PIX_W-1:0] out_stat
);

    logic [1:0]       age;
    logic [PIX_W-1:0] outs [3];

    assign outs[0] = out_mem;
    assign outs[1] = out_pipe;
    assign outs[2] = out_stat;

    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (out_valid == $past(pix_valid, 2))); // R2

    for (genvar p = 0; p < 3; p++) begin : g_chk
        AST_PATH_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd2 && out_valid && !$past(cfg_gain_en[p]) && !$past(cfg_ofs_en[p]))
            |-> (outs[p] == $past(pix_in, 2))); // R5

        AST_OFS_NOT_BELOW: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd2 && out_valid && !$past(cfg_gain_en[p]))
            |-> (outs[p] >= $past(pix_in, 2))); // R4

        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
            (age != 2'd0 && !out_valid) |-> $stable(outs[p])); // R11
    end

endmodule

bind bayer_wb_gain bwg_checker #(.PIX_W(PIX_W), .NUM_P(bwg_pkg::NUM_PATHS)) i_bwg_checker (
    .clk        (clk),
    .rst        (rst),
    .pix_valid  (pix_valid),
    .pix_in     (pix_in),
    .cfg_gain_en(cfg_gain_en),
    .cfg_ofs_en (cfg_ofs_en),
    .out_valid  (out_valid),
    .out_mem    (out_mem),
    .out_pipe   (out_pipe),
    .out_stat   (out_stat)
);

// File: tb/test_bayer_wb_gain.sv
`timescale 1ns/1ps
module test_bayer_wb_gain;

    localparam int PIX_W  = 12;
    localparam int GAIN_W = 12;
    localparam int FRAC_W = 9;
    localparam int MAXV   = (1 << PIX_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pix_valid = 1'b0;
    logic              line_start = 1'b0;
    logic              frame_start = 1'b0;
    logic              field_id = 1'b0;
    logic [PIX_W-1:0]  pix_in = '0;
    logic [GAIN_W-1:0] cfg_gain_r  = 12'h200;
    logic [GAIN_W-1:0] cfg_gain_gr = 12'h200;
    logic [GAIN_W-1:0] cfg_gain_gb = 12'h200;
    logic [GAIN_W-1:0] cfg_gain_b  = 12'h200;
    logic [15:0]       cfg_color_pat = 16'h4E4E;
    logic [11:0]       cfg_offset = '0;
    logic [2:0]        cfg_gain_en = '0;
    logic [2:0]        cfg_ofs_en = '0;
    logic              out_valid;
    logic [PIX_W-1:0]  out_mem, out_pipe, out_stat;

    always #2 clk = ~clk;

    bayer_wb_gain i_bayer_wb_gain (
        .clk          (clk),
        .rst          (rst),
        .pix_valid    (pix_valid),
        .line_start   (line_start),
        .frame_start  (frame_start),
        .field_id     (field_id),
        .pix_in       (pix_in),
        .cfg_gain_r   (cfg_gain_r),
        .cfg_gain_gr  (cfg_gain_gr),
        .cfg_gain_gb  (cfg_gain_gb),
        .cfg_gain_b   (cfg_gain_b),
        .cfg_color_pat(cfg_color_pat),
        .cfg_offset   (cfg_offset),
        .cfg_gain_en  (cfg_gain_en),
        .cfg_ofs_en   (cfg_ofs_en),
        .out_valid    (out_valid),
        .out_mem      (out_mem),
        .out_pipe     (out_pipe),
        .out_stat     (out_stat)
    );

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string phase = "R1";

    int    q_v[$], q_m[$], q_p[$], q_s[$];
    string q_t[$];

    // Behavioural position model: counts since the last strobe
    int line_cnt = 0, pix_cnt = 0, fld_lat = 0;
    int hold_m = 0, hold_p = 0, hold_s = 0;

    function automatic int gain_of(int code);
        case (code)
            0: return int'(cfg_gain_r);
            1: return int'(cfg_gain_gr);
            2: return int'(cfg_gain_gb);
            default: return int'(cfg_gain_b);
        endcase
    endfunction

    function automatic int path_value(int px, int g, bit ge, bit oe);
        int r;
        r = ge ? (px * g + (1 << (FRAC_W - 1))) / (1 << FRAC_W) : px;
        if (oe) r = r + int'(cfg_offset);
        if (r > MAXV) r = MAXV;
        return r;
    endfunction

    task automatic compare(string tag, string what, int got, int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic step(bit v, bit sol, bit sof, bit fld, int px);
        int shift, code, g;
        string tag;
        @(negedge clk);
        if (q_v.size() >= 2) begin
            tag = q_t.pop_front();
            compare({tag, " R2"}, "out_valid", int'(out_valid), q_v.pop_front());
            compare(tag, "out_mem",  int'(out_mem),  q_m.pop_front());
            compare(tag, "out_pipe", int'(out_pipe), q_p.pop_front());
            compare(tag, "out_stat", int'(out_stat), q_s.pop_front());
        end
        pix_valid   = v;
        line_start  = sol;
        frame_start = sof;
        field_id    = fld;
        pix_in      = PIX_W'(px);
        if (sof) begin
            line_cnt = 0; pix_cnt = 0; fld_lat = int'(fld);
        end else if (sol) begin
            line_cnt++; pix_cnt = 0;
        end
        if (v) begin
            shift  = fld_lat * 8 + (line_cnt % 2) * 4 + (pix_cnt % 2) * 2;
            code   = (int'(cfg_color_pat) >> shift) & 3;
            g      = gain_of(code);
            hold_m = path_value(px, g, cfg_gain_en[0], cfg_ofs_en[0]);
            hold_p = path_value(px, g, cfg_gain_en[1], cfg_ofs_en[1]);
            hold_s = path_value(px, g, cfg_gain_en[2], cfg_ofs_en[2]);
            pix_cnt++;
        end
        q_v.push_back(int'(v));
        q_m.push_back(hold_m);
        q_p.push_back(hold_p);
        q_s.push_back(hold_s);
        q_t.push_back(phase);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'($urandom % 2), 0);
    endtask

    function automatic int make_pix(int mode);
        case (mode)
            1:       return int'(($urandom % 2048) * 2 + 1);
            2:       return int'(3584 + ($urandom % 512));
            default: return int'($urandom % 4096);
        endcase
    endfunction

    // Field changes away from frame start exercise R10 throughout.
    task automatic frame(bit fld, int lines, int pixels, bit gaps, int mode);
        for (int l = 0; l < lines; l++) begin
            bit sol_p, sof_p;
            sol_p = 1'b1;
            sof_p = (l == 0);
            if (gaps && ($urandom % 2 == 0)) begin
                step(1'b0, 1'b1, sof_p, sof_p ? fld : 1'($urandom % 2), 0);
                sol_p = 1'b0;
                sof_p = 1'b0;
            end
            for (int p = 0; p < pixels; p++) begin
                if (gaps && ($urandom % 3 == 0)) idle(1 + int'($urandom % 2));
                step(1'b1, sol_p, sof_p, sof_p ? fld : 1'($urandom % 2), make_pix(mode));
                sol_p = 1'b0;
                sof_p = 1'b0;
            end
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R2 watchdog: got no completion expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // reset state expected on the first two sampled cycles
        for (int i = 0; i < 2; i++) begin
            q_v.push_back(0); q_m.push_back(0); q_p.push_back(0); q_s.push_back(0);
            q_t.push_back("R1");
        end
        idle(4);

        // Distinct gains, default pattern, mixed paths
        phase = "R2 R3 R6 R7 R8 R9";
        cfg_gain_r  = 12'h300;
        cfg_gain_gr = 12'h280;
        cfg_gain_gb = 12'h1C0;
        cfg_gain_b  = 12'h100;
        cfg_offset  = 12'd100;
        cfg_gain_en = 3'b011;
        cfg_ofs_en  = 3'b001;
        frame(1'b0, 4, 10, 1'b0, 0);
        frame(1'b0, 3, 7, 1'b0, 0);
        idle(3);

        // Gaps inside lines, strobes on idle cycles, held outputs
        phase = "R8 R9 R11";
        frame(1'b0, 6, 9, 1'b1, 0);
        idle(3);

        // Field 1 uses the upper pattern byte
        phase = "R6 R10";
        cfg_color_pat = 16'hE44E;
        frame(1'b1, 4, 8, 1'b1, 0);
        frame(1'b0, 2, 6, 1'b0, 0);
        frame(1'b1, 3, 5, 1'b0, 0);
        idle(3);

        // Saturation
        phase = "R4";
        cfg_gain_r  = 12'hFFF;
        cfg_gain_gr = 12'hFFF;
        cfg_gain_gb = 12'hE00;
        cfg_gain_b  = 12'hFFF;
        cfg_offset  = 12'd4000;
        cfg_gain_en = 3'b101;
        cfg_ofs_en  = 3'b011;
        frame(1'b0, 3, 8, 1'b0, 2);
        frame(1'b1, 2, 8, 1'b1, 0);
        idle(3);

        // Enable combinations swapped between paths
        phase = "R5";
        cfg_gain_r  = 12'h2A5;
        cfg_gain_gr = 12'h17B;
        cfg_gain_gb = 12'h3FF;
        cfg_gain_b  = 12'h0C3;
        cfg_offset  = 12'd37;
        cfg_gain_en = 3'b010;
        cfg_ofs_en  = 3'b110;
        frame(1'b0, 3, 8, 1'b1, 0);
        idle(3);

        // Half-way rounding
        phase = "R3";
        cfg_gain_r  = 12'h100;
        cfg_gain_gr = 12'h100;
        cfg_gain_gb = 12'h100;
        cfg_gain_b  = 12'h100;
        cfg_offset  = 12'd0;
        cfg_gain_en = 3'b111;
        cfg_ofs_en  = 3'b000;
        frame(1'b0, 2, 10, 1'b0, 1);
        idle(4);

        done = 1'b1;
        finish_run();
    end

endmodule